// File: doc/BRIEF.md
# Translation Response Fan-Out

This block sits on the return path of an address-translation hierarchy. Several requests that fall in the same virtual page are merged upstream and sent as one translation. When that translation comes back, this block turns the single result into one response for every original request in the merged group. Each response goes back to the requester port that issued it.

The group's members live in an outstanding table outside the block. The block reads that table one member per cycle through a registered read port. Each member returns its full virtual address and a 3-bit requester tag. For each member, the block forms a physical address, copies the translated entry's attribute bits, and raises a one-hot valid on the member's port. On the cycle the group's last response appears, it raises a free strobe carrying the virtual page number, so the table can drop its entry. The returned page size is given as a log2 code with each response, so the block serves mixed page sizes.

The response input uses a valid/ready handshake. Ready stays low while a group is being distributed.

Top module: `xlat_rsp_fanout`

## Requirements
- R1: After reset `rsp_ready` is 1, and `out_valid`, `free_valid` and `tbl_rd_en` are all 0.
- R2: A group of `rsp_count` members (1 to 8) accepted on clock edge A produces exactly one response per cycle. Member k (table index k, read in ascending order from slot `rsp_slot`) is visible in the cycle after edge A+k+2. In every other cycle `out_valid` is all zero.
- R3: Member 0 returns `rsp_paddr` exactly as received.
- R4: Every later member returns (`rsp_paddr` AND NOT mask) OR (its table virtual address AND mask), where mask = 2^`rsp_pg_lg` − 1.
- R5: `out_uncache` equals the group's `rsp_uncache` on every response of the group.
- R6: `out_system` and `out_hit` equal the group's `rsp_system` and `rsp_hit` on every response of the group.
- R7: Each response raises only bit p of `out_valid`, where p is the member's 3-bit table tag. At most one bit of `out_valid` is ever set.
- R8: `free_valid` is 1, with `free_vpn` equal to the group's `rsp_vpn`, only in the cycle that carries the group's last response. It occurs exactly once per group.
- R9: `rsp_ready` is 0 from the cycle after acceptance until the cycle that shows the last response, when it returns to 1. A `rsp_valid` presented while `rsp_ready` is 0 starts nothing and changes no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_valid | input | 1 | Translation result present |
| rsp_ready | output | 1 | Block can take a translation result |
| rsp_vpn | input | 36 | Virtual page number of the group |
| rsp_slot | input | 2 | Outstanding-table slot holding the group |
| rsp_count | input | 4 | Number of members in the group (1 to 8) |
| rsp_paddr | input | 48 | Translated physical address of member 0 |
| rsp_pg_lg | input | 6 | log2 of the translated page size |
| rsp_uncache | input | 1 | Translated page is uncacheable |
| rsp_system | input | 1 | Translated page is a system page |
| rsp_hit | input | 2 | Hierarchy level where the translation hit |
| tbl_rd_en | output | 1 | Outstanding-table read strobe |
| tbl_rd_slot | output | 2 | Slot being read |
| tbl_rd_idx | output | 3 | Member index being read |
| tbl_va | input | 48 | Member virtual address, one cycle after the read |
| tbl_port | input | 3 | Member requester tag, one cycle after the read |
| out_valid | output | 8 | One-hot response valid, one bit per requester port |
| out_paddr | output | 48 | Response physical address |
| out_uncache | output | 1 | Response uncacheable flag |
| out_system | output | 1 | Response system flag |
| out_hit | output | 2 | Response hit level |
| free_valid | output | 1 | Release the outstanding entry |
| free_vpn | output | 36 | Virtual page number being released |

## Verification
The cycle accounting between the member counter and the pending stage is the riskiest state. An off-by-one there shows in the first group as a missing, repeated or shifted response cycle. It also shows as a free strobe that lands away from the last response, or as ready returning early. A stale first-member flag or page-size code shows in the very response it affects, as a wrong offset below the page base. The comparison runs every cycle, so a fault shows within one group of the cycle where the internal state went wrong.

// File: rtl/xrf_pkg.sv
package xrf_pkg;
    localparam int VA_W     = 48;
    localparam int PA_W     = 48;
    localparam int PG_LG_W  = 6;
    localparam int HIT_W    = 2;
    localparam int PORT_W   = 3;
    localparam int SLOT_W   = 2;
    localparam int MAX_GRP  = 8;
    localparam int N_PORT   = 1 << PORT_W;
    localparam int IDX_W    = $clog2(MAX_GRP);
    localparam int CNT_W    = $clog2(MAX_GRP + 1);
    localparam int VPN_W    = VA_W - 12;

    typedef struct packed {
        logic              uncache;
        logic              system;
        logic [HIT_W-1:0]  hit;
    } attr_t;

    typedef enum logic {ST_IDLE, ST_RUN} fan_st_e;

    function automatic logic [PA_W-1:0] off_mask(input logic [PG_LG_W-1:0] lg);
        off_mask = (PA_W'(1) << lg) - PA_W'(1);
    endfunction
endpackage

// File: rtl/xrf_ctrl.sv
module xrf_ctrl import xrf_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  logic [CNT_W-1:0] cnt_in,
    output logic             busy,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_idx,
    output logic             pend_v,
    output logic             pend_first,
    output logic             pend_last
);
    fan_st_e          st_q;
    logic [CNT_W-1:0] grp_cnt_q;
    logic [CNT_W-1:0] rd_cnt_q;

    always_comb begin
        busy   = (st_q == ST_RUN);
        rd_en  = (st_q == ST_RUN) && (rd_cnt_q < grp_cnt_q);
        rd_idx = rd_cnt_q[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            grp_cnt_q  <= '0;
            rd_cnt_q   <= '0;
            pend_v     <= 1'b0;
            pend_first <= 1'b0;
            pend_last  <= 1'b0;
        end else begin
            pend_v     <= rd_en;
            pend_first <= rd_en && (rd_cnt_q == '0);
            pend_last  <= rd_en && (rd_cnt_q == grp_cnt_q - CNT_W'(1));
            case (st_q)
                ST_IDLE: begin
                    if (acc) begin
                        st_q      <= ST_RUN;
                        grp_cnt_q <= cnt_in;
                        rd_cnt_q  <= '0;
                    end
                end
                default: begin
                    if (rd_en)
                        rd_cnt_q <= rd_cnt_q + CNT_W'(1);
                    if (pend_v && pend_last)
                        st_q <= ST_IDLE;
                end
            endcase
        end
    end

    // R9: an accepted group holds the block busy on the next cycle
    a_r9_busy_after_acc: assert property (@(posedge clk) disable iff (rst)
        acc |=> busy);

    // R2: reads advance by exactly one index per cycle within a group
    a_r2_read_step: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en)) |-> (rd_idx == $past(rd_idx) + IDX_W'(1)));

    // R2: the pending stage follows a read by one cycle
    a_r2_pend_follows: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> pend_v);
endmodule

// File: rtl/xrf_compose.sv
module xrf_compose import xrf_pkg::*; (
    input  logic               first,
    input  logic [PG_LG_W-1:0] lg,
    input  logic [PA_W-1:0]    pa_ret,
    input  logic [VA_W-1:0]    va,
    output logic [PA_W-1:0]    pa
);
    logic [PA_W-1:0] mask;
    logic [PA_W-1:0] base;

    always_comb begin
        mask = off_mask(lg);
        base = pa_ret & ~mask;
        pa   = first ? pa_ret : (base | (PA_W'(va) & mask));
    end
endmodule

// File: rtl/xrf_route.sv
module xrf_route import xrf_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic              last,
    input  logic [PORT_W-1:0] port,
    input  logic [PA_W-1:0]   pa,
    input  attr_t             attr,
    input  logic [VPN_W-1:0]  vpn,
    output logic [N_PORT-1:0] out_valid,
    output logic [PA_W-1:0]   out_pa,
    output attr_t             out_attr,
    output logic              free_v,
    output logic [VPN_W-1:0]  free_vpn
);
    for (genvar p = 0; p < N_PORT; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst)
                out_valid[p] <= 1'b0;
            else
                out_valid[p] <= ld && (port == PORT_W'(p));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_pa   <= '0;
            out_attr <= '0;
            free_v   <= 1'b0;
            free_vpn <= '0;
        end else begin
            free_v <= ld && last;
            if (ld) begin
                out_pa   <= pa;
                out_attr <= attr;
            end
            if (ld && last)
                free_vpn <= vpn;
        end
    end

    // R7: never more than one requester port at a time
    a_r7_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_valid));

    // R8: the release strobe rides on a response cycle
    a_r8_free_with_rsp: assert property (@(posedge clk) disable iff (rst)
        free_v |-> (out_valid != '0));
endmodule

// File: rtl/xlat_rsp_fanout.sv
module xlat_rsp_fanout import xrf_pkg::*; (
    input  logic               clk,
    input  logic               rst,
    input  logic               rsp_valid,
    output logic               rsp_ready,
    input  logic [VPN_W-1:0]   rsp_vpn,
    input  logic [SLOT_W-1:0]  rsp_slot,
    input  logic [CNT_W-1:0]   rsp_count,
    input  logic [PA_W-1:0]    rsp_paddr,
    input  logic [PG_LG_W-1:0] rsp_pg_lg,
    input  logic               rsp_uncache,
    input  logic               rsp_system,
    input  logic [HIT_W-1:0]   rsp_hit,
    output logic               tbl_rd_en,
    output logic [SLOT_W-1:0]  tbl_rd_slot,
    output logic [IDX_W-1:0]   tbl_rd_idx,
    input  logic [VA_W-1:0]    tbl_va,
    input  logic [PORT_W-1:0]  tbl_port,
    output logic [N_PORT-1:0]  out_valid,
    output logic [PA_W-1:0]    out_paddr,
    output logic               out_uncache,
    output logic               out_system,
    output logic [HIT_W-1:0]   out_hit,
    output logic               free_valid,
    output logic [VPN_W-1:0]   free_vpn
);
    logic               acc;
    logic               busy;
    logic               pend_v;
    logic               pend_first;
    logic               pend_last;
    logic [PA_W-1:0]    member_pa;
    attr_t              out_attr;

    logic [VPN_W-1:0]   grp_vpn_q;
    logic [SLOT_W-1:0]  grp_slot_q;
    logic [PA_W-1:0]    grp_pa_q;
    logic [PG_LG_W-1:0] grp_lg_q;
    attr_t              grp_attr_q;

    assign rsp_ready   = !busy;
    assign acc         = rsp_valid && rsp_ready;
    assign tbl_rd_slot = grp_slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_vpn_q  <= '0;
            grp_slot_q <= '0;
            grp_pa_q   <= '0;
            grp_lg_q   <= '0;
            grp_attr_q <= '0;
        end else if (acc) begin
            grp_vpn_q  <= rsp_vpn;
            grp_slot_q <= rsp_slot;
            grp_pa_q   <= rsp_paddr;
            grp_lg_q   <= rsp_pg_lg;
            grp_attr_q <= '{uncache: rsp_uncache, system: rsp_system, hit: rsp_hit};
        end
    end

    xrf_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .cnt_in     (rsp_count),
        .busy       (busy),
        .rd_en      (tbl_rd_en),
        .rd_idx     (tbl_rd_idx),
        .pend_v     (pend_v),
        .pend_first (pend_first),
        .pend_last  (pend_last)
    );

    xrf_compose u_compose (
        .first  (pend_first),
        .lg     (grp_lg_q),
        .pa_ret (grp_pa_q),
        .va     (tbl_va),
        .pa     (member_pa)
    );

    xrf_route u_route (
        .clk       (clk),
        .rst       (rst),
        .ld        (pend_v),
        .last      (pend_last),
        .port      (tbl_port),
        .pa        (member_pa),
        .attr      (grp_attr_q),
        .vpn       (grp_vpn_q),
        .out_valid (out_valid),
        .out_pa    (out_paddr),
        .out_attr  (out_attr),
        .free_v    (free_valid),
        .free_vpn  (free_vpn)
    );

    assign out_uncache = out_attr.uncache;
    assign out_system  = out_attr.system;
    assign out_hit     = out_attr.hit;

    // R2: group size must lie in the supported range when taken
    a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
        acc |-> (rsp_count != '0 && rsp_count <= CNT_W'(MAX_GRP)));

    // R9: ready drops right after an acceptance
    a_r9_ready_drop: assert property (@(posedge clk) disable iff (rst)
        acc |=> !rsp_ready);

    // R8: one release per group, never on two adjacent cycles
    a_r8_free_once: assert property (@(posedge clk) disable iff (rst)
        free_valid |=> !free_valid);

    // R4: every response keeps the translated page base
    a_r4_page_base: assert property (@(posedge clk) disable iff (rst)
        (out_valid != '0) |-> (((out_paddr ^ grp_pa_q) & ~off_mask(grp_lg_q)) == '0));

    // R5: uncacheable flag follows the group on every response
    a_r5_uncache: assert property (@(posedge clk) disable iff (rst)
        (out_valid != '0) |-> (out_uncache == grp_attr_q.uncache));
endmodule

// File: tb/tb_xlat_rsp_fanout.sv
module tb_xlat_rsp_fanout;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready;
    logic [35:0] rsp_vpn = '0;
    logic [1:0]  rsp_slot = '0;
    logic [3:0]  rsp_count = 4'd1;
    logic [47:0] rsp_paddr = '0;
    logic [5:0]  rsp_pg_lg = '0;
    logic        rsp_uncache = 1'b0;
    logic        rsp_system = 1'b0;
    logic [1:0]  rsp_hit = '0;
    logic        tbl_rd_en;
    logic [1:0]  tbl_rd_slot;
    logic [2:0]  tbl_rd_idx;
    logic [47:0] tbl_va = '0;
    logic [2:0]  tbl_port = '0;
    logic [7:0]  out_valid;
    logic [47:0] out_paddr;
    logic        out_uncache;
    logic        out_system;
    logic [1:0]  out_hit;
    logic        free_valid;
    logic [35:0] free_vpn;

    always #4 clk = ~clk;

    xlat_rsp_fanout dut (.*);

    typedef struct {
        int          cyc;
        int          port;
        logic [47:0] pa;
        logic        unc;
        logic        sys;
        logic [1:0]  hit;
        bit          first;
        bit          last;
        logic [35:0] vpn;
    } exp_t;

    exp_t        exp_q[$];
    logic [47:0] tva [4][8];
    logic [2:0]  tpt [4][8];
    int cyc = 0;
    int errors = 0;
    int checks = 0;
    int blo = -1;
    int bhi = -2;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tbl_rd_en) begin
            tbl_va   <= tva[tbl_rd_slot][tbl_rd_idx];
            tbl_port <= tpt[tbl_rd_slot][tbl_rd_idx];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, expv);
        end
    endtask

    // per-cycle reference comparison
    always @(negedge clk) begin
        if (mon_on) begin
            automatic bit rdy_exp = !(cyc >= blo && cyc <= bhi);
            chk(rsp_ready == rdy_exp, "R9", "rsp_ready", rsp_ready, rdy_exp);
            if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
                automatic exp_t e = exp_q.pop_front();
                chk(out_valid == (8'd1 << e.port), "R7", "out_valid", out_valid, 8'd1 << e.port);
                if (e.first)
                    chk(out_paddr == e.pa, "R3", "first paddr", out_paddr, e.pa);
                else
                    chk(out_paddr == e.pa, "R4", "member paddr", out_paddr, e.pa);
                chk(out_uncache == e.unc, "R5", "uncache", out_uncache, e.unc);
                chk({out_system, out_hit} == {e.sys, e.hit}, "R6", "system/hit",
                    {out_system, out_hit}, {e.sys, e.hit});
                chk(free_valid == e.last, "R8", "free_valid", free_valid, e.last);
                if (e.last)
                    chk(free_vpn == e.vpn, "R8", "free_vpn", free_vpn, e.vpn);
            end else begin
                chk(out_valid == 8'd0, "R2", "idle out_valid", out_valid, 0);
                chk(free_valid == 1'b0, "R8", "idle free_valid", free_valid, 0);
            end
        end
    end

    task automatic send(input int slot, input logic [35:0] vpn, input logic [47:0] pa,
                        input int lg, input int n, input bit unc, input bit sys,
                        input logic [1:0] hit);
        int c;
        logic [47:0] mask;
        @(negedge clk);
        while (!rsp_ready) @(negedge clk);
        rsp_valid   = 1'b1;
        rsp_slot    = 2'(slot);
        rsp_vpn     = vpn;
        rsp_paddr   = pa;
        rsp_pg_lg   = 6'(lg);
        rsp_count   = 4'(n);
        rsp_uncache = unc;
        rsp_system  = sys;
        rsp_hit     = hit;
        c    = cyc;
        mask = (48'd1 << lg) - 48'd1;
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.cyc   = c + 3 + k;
            e.port  = int'(tpt[slot][k]);
            e.pa    = (k == 0) ? pa : ((pa & ~mask) | (tva[slot][k] & mask));
            e.unc   = unc;
            e.sys   = sys;
            e.hit   = hit;
            e.first = (k == 0);
            e.last  = (k == n - 1);
            e.vpn   = vpn;
            exp_q.push_back(e);
        end
        blo = c + 1;
        bhi = c + n + 1;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    // R9: offer junk while busy; it must be ignored
    task automatic junk(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            rsp_valid   = 1'b1;
            rsp_slot    = 2'd3;
            rsp_vpn     = 36'hFFF_FFFF_FF;
            rsp_paddr   = 48'hDEAD_BEEF_0000;
            rsp_pg_lg   = 6'd12;
            rsp_count   = 4'd8;
            rsp_uncache = 1'b1;
            @(negedge clk);
        end
        rsp_valid = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < 8; k++) begin
                tva[s][k] = 48'h7F00_0000_0000 | (48'(s) << 30)
                          | (48'(k) * 48'h0004_5678) + 48'(37 * (s + 1) + 11 * k);
                tpt[s][k] = 3'((s * 3 + k * 5) % 8);
            end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(rsp_ready == 1'b1, "R1", "reset ready", rsp_ready, 1);
        chk(out_valid == 8'd0, "R1", "reset out_valid", out_valid, 0);
        chk(free_valid == 1'b0, "R1", "reset free_valid", free_valid, 0);
        chk(tbl_rd_en == 1'b0, "R1", "reset tbl_rd_en", tbl_rd_en, 0);
        mon_on = 1'b1;

        send(0, 36'h1_2345_678, 48'h0000_89AB_C123, 12, 1, 1'b0, 1'b0, 2'd1);
        send(1, 36'h0_0042_001, 48'h0012_3456_7ABC, 12, 4, 1'b1, 1'b0, 2'd2);
        send(2, 36'h0_0000_400, 48'h0000_4060_0321, 21, 3, 1'b0, 1'b1, 2'd3);
        send(3, 36'h0_FFFF_FFF, 48'hFFFF_FFFF_F000, 12, 8, 1'b1, 1'b1, 2'd0);
        send(1, 36'h0_0000_777, 48'h0000_0777_0000, 16, 4, 1'b0, 1'b1, 2'd1);
        junk(2);
        send(0, 36'h0_0000_ABC, 48'h0000_C000_0FFF, 30, 2, 1'b1, 1'b0, 2'd2);
        send(2, 36'h0_0000_123, 48'h0000_0001_2000, 12, 5, 1'b0, 1'b0, 2'd3);
        send(3, 36'h0_0000_555, 48'h0000_5555_5555, 14, 1, 1'b1, 1'b1, 2'd1);

        while (exp_q.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            summary();
        end
    end
endmodule